// File: doc/BRIEF.md
# Dual 16-bit Timer/Counter Unit

This block provides two independent 16-bit timer/counter channels that share a mode register and a control register. A divider turns the input clock into a machine-cycle pulse, one every twelve clocks. In timer mode a channel advances on that pulse. In counter mode it advances once for each high-to-low transition seen on its external count pin. Each channel has a run bit and an optional gate qualifier. A two-bit field per channel selects one of four counting layouts.

Software reaches the unit through a small register port. A write is accepted in one cycle, and the read data is a combinational view of the addressed register. When a channel wraps, it raises a sticky overflow flag in the control register. Software clears that flag by writing 0 to it. The unit does not drive interrupts or pin multiplexing.

Top module: `dual_tmr_unit`

## Requirements
- R1: One machine cycle is 12 clocks. In timer mode, a running channel advances by exactly 1 per machine cycle, so a run window of 12*N clocks adds N.
- R2: In counter mode (mode-nibble bit 2 = 1), a running channel advances by 1 for each 1-to-0 transition of its count pin, provided each level is held for at least one machine cycle. The pin is sampled once per machine cycle, so at most one count occurs every two machine cycles.
- R3: Layout 01 is a 16-bit counter {high,low}. It wraps from 0xFFFF to 0x0000 and sets the channel's flag.
- R4: Layout 00 is a 13-bit counter {high[7:0], low[4:0]}. Low-byte bits 7:5 are left unchanged, and a wrap from all ones sets the flag.
- R5: Layout 10 advances only the low byte. When the low byte wraps from 0xFF it is reloaded from the high byte and the flag is set. The high byte is unchanged.
- R6: With channel 0 in layout 11, channel 0's low byte is an 8-bit counter under channel 0's run, gate and source controls, and it sets flag 0. Channel 0's high byte is an 8-bit timer that runs on run bit 1 and sets flag 1. In this state, wraps of channel 1 do not set flag 1.
- R7: Channel 1 in layout 11 holds its count even while run bit 1 is set.
- R8: With the gate bit (mode-nibble bit 3) set, a channel counts only while its run bit and its gate pin are both high. With the gate bit clear, the gate pin is ignored.
- R9: A channel whose run bit is clear holds its count, whatever its count pin does.
- R10: A flag stays set until a control write puts 0 in its bit. Writing 1 has no effect. A hardware set in the same cycle as a clearing write wins.
- R11: Register map: address 0 is mode (bits 7:4 channel 1, bits 3:0 channel 0). Address 1 is control (bit 7 flag 1, bit 6 run 1, bit 5 flag 0, bit 4 run 0, bits 3:0 read 0). Addresses 2/3 are channel 0 low/high, addresses 4/5 are channel 1 low/high, and addresses 6 and 7 read 0. Every register resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| ext_cnt | input | 2 | External count pins, bit i for channel i |
| ext_gate | input | 2 | External gate pins, bit i for channel i |

## Verification
The hardest case to create from the ports is a count that lands in the same cycle as a register write. This matters most when a clearing control write coincides with a wrap, because the phase of the machine cycle is not visible outside the block. The bench avoids guessing that phase. It opens run windows that are an exact multiple of twelve clocks, which makes the number of ticks inside each window known whatever the phase. A checker covers the same-cycle set-versus-clear case every time it happens. Random preloads and window lengths place wraps at varying positions within a window, including the final tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W   = 8;
  localparam int LOW13_W  = 5;
  localparam int ADDR_W   = 3;
  localparam int NUM_CH   = 2;
  localparam int NIBBLE_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_MODE   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CH0_LO = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CH0_HI = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CH1_LO = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_CH1_HI = 3'd5;

  typedef enum logic [1:0] {
    LAYOUT_13BIT  = 2'b00,
    LAYOUT_16BIT  = 2'b01,
    LAYOUT_RELOAD = 2'b10,
    LAYOUT_SPLIT  = 2'b11
  } tmr_layout_e;

  typedef struct packed {
    logic        gate_on;
    logic        pin_src;
    tmr_layout_e layout;
  } tmr_cfg_t;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tmr_mc_pacer.sv
module tmr_mc_pacer #(
  parameter int CLKS_PER_MC = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = $clog2(CLKS_PER_MC);
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MC - 1);

  logic [CW-1:0] div_q, div_d;

  assign tick = (div_q == LAST);

  always_comb begin
    if (tick) div_d = '0;
    else      div_d = div_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/tmr_pin_cond.sv
module tmr_pin_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic level,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic smp_q, smp_d, prev_q, prev_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
  end

  assign level = sync_q[SYNC_STAGES-1];

  // sample once per machine cycle; keep the previous sample
  always_comb begin
    smp_d  = smp_q;
    prev_d = prev_q;
    if (tick) begin
      smp_d  = level;
      prev_d = smp_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      smp_q  <= smp_d;
      prev_q <= prev_d;
    end
  end

  assign fall = prev_q & ~smp_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter bit SPLIT_CAPABLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_layout_e       layout,
  input  logic              step,
  input  logic              hi_step,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] hi,
  output logic              wrap,
  output logic              hi_wrap
);
  logic [BYTE_W-1:0] lo_q, hi_q, lo_d, hi_d;

  always_comb begin
    lo_d    = lo_q;
    hi_d    = hi_q;
    wrap    = 1'b0;
    hi_wrap = 1'b0;
    case (layout)
      LAYOUT_13BIT: if (step) begin
        {hi_d, lo_d[LOW13_W-1:0]} = {hi_q, lo_q[LOW13_W-1:0]} + (BYTE_W+LOW13_W)'(1);
        wrap = &{hi_q, lo_q[LOW13_W-1:0]};
      end
      LAYOUT_16BIT: if (step) begin
        {hi_d, lo_d} = {hi_q, lo_q} + (2*BYTE_W)'(1);
        wrap = &{hi_q, lo_q};
      end
      LAYOUT_RELOAD: if (step) begin
        if (&lo_q) begin
          lo_d = hi_q;
          wrap = 1'b1;
        end else begin
          lo_d = lo_q + BYTE_W'(1);
        end
      end
      LAYOUT_SPLIT: if (SPLIT_CAPABLE) begin
        if (step) begin
          lo_d = lo_q + BYTE_W'(1);
          wrap = &lo_q;
        end
        if (hi_step) begin
          hi_d    = hi_q + BYTE_W'(1);
          hi_wrap = &hi_q;
        end
      end
      default: ;
    endcase
    if (wr_lo) lo_d = wdata;
    if (wr_hi) hi_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo = lo_q;
  assign hi = hi_q;
endmodule

// File: rtl/dual_tmr_unit.sv
module dual_tmr_unit
  import tmr_pkg::*;
#(
  parameter int CLKS_PER_MC = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic [NUM_CH-1:0] ext_cnt,
  input  logic [NUM_CH-1:0] ext_gate
);
  logic rst_i_n;
  logic mc_tick;

  logic [BYTE_W-1:0] mode_q, mode_d;
  logic [NUM_CH-1:0] run_q, run_d, flag_q, flag_d, flag_set;
  logic [NUM_CH-1:0] pin_fall, gate_lvl, ch_step, ch_wrap, ch_hi_wrap;
  logic [BYTE_W-1:0] cnt_lo [NUM_CH];
  logic [BYTE_W-1:0] cnt_hi [NUM_CH];
  tmr_cfg_t          cfg    [NUM_CH];
  logic              wr_ctrl, split0;
  logic [NUM_CH-1:0] ctrl_run_bits, ctrl_flag_bits;

  tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  tmr_mc_pacer #(.CLKS_PER_MC(CLKS_PER_MC)) u_pacer (
    .clk(clk), .rst_n(rst_i_n), .tick(mc_tick)
  );

  assign split0 = (cfg[0].layout == LAYOUT_SPLIT);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign cfg[ch] = tmr_cfg_t'(mode_q[ch*NIBBLE_W +: NIBBLE_W]);

    tmr_pin_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cnt_pin (
      .clk(clk), .rst_n(rst_i_n), .tick(mc_tick), .pin(ext_cnt[ch]),
      .level(), .fall(pin_fall[ch])
    );

    tmr_pin_cond #(.SYNC_STAGES(SYNC_STAGES)) u_gate_pin (
      .clk(clk), .rst_n(rst_i_n), .tick(mc_tick), .pin(ext_gate[ch]),
      .level(gate_lvl[ch]), .fall()
    );

    assign ch_step[ch] = mc_tick & run_q[ch]
                       & (~cfg[ch].gate_on | gate_lvl[ch])
                       & (~cfg[ch].pin_src | pin_fall[ch]);

    tmr_channel #(.SPLIT_CAPABLE(ch == 0)) u_chan (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .layout  (cfg[ch].layout),
      .step    (ch_step[ch]),
      .hi_step ((ch == 0) ? (mc_tick & run_q[1]) : 1'b0),
      .wr_lo   (wr_en && (addr == ADDR_CH0_LO + ADDR_W'(2*ch))),
      .wr_hi   (wr_en && (addr == ADDR_CH0_HI + ADDR_W'(2*ch))),
      .wdata   (wdata),
      .lo      (cnt_lo[ch]),
      .hi      (cnt_hi[ch]),
      .wrap    (ch_wrap[ch]),
      .hi_wrap (ch_hi_wrap[ch])
    );
  end

  // flag 1 is taken over by channel 0's high byte in the split layout
  assign flag_set[0] = ch_wrap[0];
  assign flag_set[1] = split0 ? ch_hi_wrap[0] : ch_wrap[1];

  assign wr_ctrl        = wr_en && (addr == ADDR_CTRL);
  assign ctrl_run_bits  = {wdata[6], wdata[4]};
  assign ctrl_flag_bits = {wdata[7], wdata[5]};

  always_comb begin
    mode_d = mode_q;
    if (wr_en && (addr == ADDR_MODE)) mode_d = wdata;
    run_d = wr_ctrl ? ctrl_run_bits : run_q;
    for (int i = 0; i < NUM_CH; i++) begin
      flag_d[i] = flag_set[i] | (flag_q[i] & ~(wr_ctrl & ~ctrl_flag_bits[i]));
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      mode_q <= mode_d;
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    case (addr)
      ADDR_MODE:   rdata = mode_q;
      ADDR_CTRL:   rdata = {flag_q[1], run_q[1], flag_q[0], run_q[0], 4'b0000};
      ADDR_CH0_LO: rdata = cnt_lo[0];
      ADDR_CH0_HI: rdata = cnt_hi[0];
      ADDR_CH1_LO: rdata = cnt_lo[1];
      ADDR_CH1_HI: rdata = cnt_hi[1];
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_tmr_chk.sv
module dual_tmr_chk #(
  parameter int CLKS_PER_MC = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] mode_q,
  input logic [1:0] run_q,
  input logic [1:0] flag_q,
  input logic [7:0] lo0,
  input logic [7:0] hi0,
  input logic [7:0] lo1,
  input logic [7:0] hi1,
  input logic       wrap0
);
  localparam int GW = $clog2(CLKS_PER_MC) + 1;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gap_q <= '0;
    else if (tick) gap_q <= '0;
    else           gap_q <= gap_q + GW'(1);
  end

  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap_q == GW'(CLKS_PER_MC - 1)));

  p_no_count_off_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> ($stable(lo0) && $stable(hi0) && $stable(lo1) && $stable(hi1)));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'b10 && lo0 == 8'hFF && !wr_en) |=> (lo0 == 8'hFF || lo0 == $past(hi0)));

  p_ch1_split_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[5:4] == 2'b11 && !(wr_en && (addr == 3'd4 || addr == 3'd5)))
      |=> ($stable(lo1) && $stable(hi1)));

  p_stopped_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q[0] && !(wr_en && addr == 3'd2)) |=> $stable(lo0));

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[0] && !(wr_en && addr == 3'd1 && !wdata[5])) |=> flag_q[0]);

  p_flag_rise_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[0]) |-> $past(tick));

  p_set_beats_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap0 && wr_en && addr == 3'd1 && !wdata[5]) |=> flag_q[0]);
endmodule

bind dual_tmr_unit dual_tmr_chk #(.CLKS_PER_MC(CLKS_PER_MC)) i_chk (
  .clk(clk), .rst_n(rst_i_n), .tick(mc_tick), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .mode_q(mode_q), .run_q(run_q), .flag_q(flag_q),
  .lo0(cnt_lo[0]), .hi0(cnt_hi[0]), .lo1(cnt_lo[1]), .hi1(cnt_hi[1]),
  .wrap0(ch_wrap[0])
);

// File: tb/test_dual_tmr_unit.sv
module test_dual_tmr_unit;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [1:0] ext_cnt;
  logic [1:0] ext_gate;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  dual_tmr_unit i_dual_tmr_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ext_cnt(ext_cnt), .ext_gate(ext_gate)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [16:0] add16(input logic [15:0] base, input int n);
    return {1'b0, base} + 17'(n);
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [7:0] e);
    logic [7:0] v;
    bus_rd(a, v);
    chk(req, v, e);
  endtask

  // run bits high for exactly 12*n clocks; flag bits written as 1 are left alone
  task automatic run_window(input logic [7:0] on_val, input int n);
    bus_wr(3'd1, on_val);
    repeat (12*n - 2) @(negedge clk);
    bus_wr(3'd1, 8'hA0);
  endtask

  task automatic pin_falls(input int k);
    for (int i = 0; i < k; i++) begin
      ext_cnt[0] = 1'b0;
      repeat (36) @(negedge clk);
      ext_cnt[0] = 1'b1;
      repeat (36) @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] pre;
    logic [16:0] sum;
    int          n;
    void'($urandom(32'd4711));
    wr_en = 1'b0; addr = '0; wdata = '0;
    ext_cnt = 2'b11; ext_gate = 2'b00;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11 reset state of every address
    for (int a = 0; a < 8; a++) expect_reg("R11 reset", 3'(a), 8'h00);

    // R11 map: mode readback, control low nibble, unused addresses
    bus_wr(3'd0, 8'hA5);
    expect_reg("R11 mode readback", 3'd0, 8'hA5);
    bus_wr(3'd1, 8'h0F);
    expect_reg("R11 control low nibble", 3'd1, 8'h00);
    bus_wr(3'd6, 8'h55);
    expect_reg("R11 unused address", 3'd6, 8'h00);

    // R1 timer pace: 7 machine cycles
    bus_wr(3'd0, 8'h11);
    bus_wr(3'd2, 8'h00); bus_wr(3'd3, 8'h00);
    run_window(8'hB0, 7);
    expect_reg("R1 timer low", 3'd2, 8'h07);
    expect_reg("R1 timer high", 3'd3, 8'h00);
    expect_reg("R9 channel 1 idle", 3'd4, 8'h00);

    // R3 16-bit wrap
    bus_wr(3'd2, 8'hFE); bus_wr(3'd3, 8'hFF);
    run_window(8'hB0, 3);
    expect_reg("R3 low", 3'd2, 8'h01);
    expect_reg("R3 high", 3'd3, 8'h00);
    expect_reg("R3 flag", 3'd1, 8'h20);

    // R10 sticky flag, write-1 no effect, write-0 clear
    repeat (100) @(negedge clk);
    expect_reg("R10 sticky", 3'd1, 8'h20);
    bus_wr(3'd1, 8'hA0);
    expect_reg("R10 write one keeps", 3'd1, 8'h20);
    bus_wr(3'd1, 8'h00);
    expect_reg("R10 cleared", 3'd1, 8'h00);
    bus_wr(3'd1, 8'hA0);
    expect_reg("R10 write one no set", 3'd1, 8'h00);

    // R4 13-bit layout
    bus_wr(3'd0, 8'h00);
    bus_wr(3'd2, 8'hFE); bus_wr(3'd3, 8'hFF);
    run_window(8'hB0, 2);
    expect_reg("R4 low keeps upper bits", 3'd2, 8'hE0);
    expect_reg("R4 high", 3'd3, 8'h00);
    expect_reg("R4 flag", 3'd1, 8'h20);
    bus_wr(3'd1, 8'h00);

    // R5 auto-reload
    bus_wr(3'd0, 8'h02);
    bus_wr(3'd2, 8'hFE); bus_wr(3'd3, 8'hF0);
    run_window(8'hB0, 5);
    expect_reg("R5 low reloaded", 3'd2, 8'hF3);
    expect_reg("R5 high unchanged", 3'd3, 8'hF0);
    expect_reg("R5 flag", 3'd1, 8'h20);
    bus_wr(3'd1, 8'h00);

    // R6 split layout on channel 0, channel 1 wraps without flag
    bus_wr(3'd0, 8'h13);
    bus_wr(3'd2, 8'hFE); bus_wr(3'd3, 8'h10);
    bus_wr(3'd4, 8'hFF); bus_wr(3'd5, 8'hFF);
    run_window(8'hF0, 3);
    expect_reg("R6 low byte", 3'd2, 8'h01);
    expect_reg("R6 high byte", 3'd3, 8'h13);
    expect_reg("R6 channel 1 low", 3'd4, 8'h02);
    expect_reg("R6 channel 1 high", 3'd5, 8'h00);
    expect_reg("R6 flags", 3'd1, 8'h20);
    bus_wr(3'd1, 8'h00);

    // R7 channel 1 split holds
    bus_wr(3'd0, 8'h31);
    bus_wr(3'd2, 8'h00); bus_wr(3'd3, 8'h00);
    bus_wr(3'd4, 8'h34); bus_wr(3'd5, 8'h12);
    run_window(8'hF0, 5);
    expect_reg("R7 channel 1 low", 3'd4, 8'h34);
    expect_reg("R7 channel 1 high", 3'd5, 8'h12);
    expect_reg("R7 channel 0 runs", 3'd2, 8'h05);

    // R8 gate on channel 1
    bus_wr(3'd0, 8'h90);
    bus_wr(3'd4, 8'h00); bus_wr(3'd5, 8'h00);
    ext_gate[1] = 1'b0;
    run_window(8'hE0, 4);
    expect_reg("R8 gate low blocks", 3'd4, 8'h00);
    ext_gate[1] = 1'b1;
    repeat (5) @(negedge clk);
    run_window(8'hE0, 4);
    expect_reg("R8 gate high counts", 3'd4, 8'h04);
    ext_gate[1] = 1'b0;

    // R2 counter mode on channel 0
    bus_wr(3'd0, 8'h05);
    bus_wr(3'd2, 8'h00); bus_wr(3'd3, 8'h00);
    bus_wr(3'd1, 8'hB0);
    pin_falls(5);
    repeat (60) @(negedge clk);
    bus_wr(3'd1, 8'hA0);
    expect_reg("R2 falling edges", 3'd2, 8'h05);

    // R9 stopped channel ignores pin
    pin_falls(2);
    repeat (40) @(negedge clk);
    expect_reg("R9 stopped holds", 3'd2, 8'h05);

    // R3 random preloads with R1 window lengths
    bus_wr(3'd0, 8'h01);
    for (int it = 0; it < 20; it++) begin
      pre = 16'($urandom);
      if (it % 4 == 0) pre = 16'hFFF0 | 16'($urandom_range(0, 15));
      n = $urandom_range(1, 20);
      bus_wr(3'd1, 8'h00);
      bus_wr(3'd2, pre[7:0]); bus_wr(3'd3, pre[15:8]);
      run_window(8'hB0, n);
      sum = add16(pre, n);
      expect_reg("R3 random low", 3'd2, sum[7:0]);
      expect_reg("R3 random high", 3'd3, sum[15:8]);
      expect_reg("R3 random flag", 3'd1, sum[16] ? 8'h20 : 8'h00);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule